// File: doc/BRIEF.md
# Serial Receive Character Queue

This block sits between the bit-level deserializer of an asynchronous serial receiver and a register bus. Each received character enters a 16-deep queue with three per-character line condition flags: break, framing error and parity error. Software reads characters from a data register. A status register always shows the fill count, an empty indication and the flags of the character currently at the head of the queue, so an error is seen before the affected character is read.

The block raises an interrupt when the fill count reaches a programmable level. It also raises one when characters have waited in the queue too long without a new arrival. Both conditions are latched as status bits. Software clears them by writing 0 to them.

A character that arrives when the queue is full is dropped, and an overrun indication is raised. The queue can be emptied by a guarded reset command, or the whole block can be returned to its reset state by a soft reset bit that clears itself.

Top module: `uart_rx_fifo`

Register map (`reg_addr`):
- 0: data. Bits 7:0 hold the head character, or 0 when the queue is empty. A read pops one entry.
- 1: status.
- 2: control.
- 3: timeout limit.

## Requirements
- R1: The queue stores up to 16 characters and delivers them in arrival order. Status bits 4:0 hold the number of stored characters.
- R2: Status bit 14 reads 1 when the queue is empty and 0 when a character can be read.
- R3: Status bit 15 (break), bit 13 (framing) and bit 12 (parity) show the flags of the head character, and read 0 when the queue is empty. A read of address 0 with `reg_rd` high returns the head character in bits 7:0 and removes it at the next clock edge, so the status shows the next entry's flags from the following cycle.
- R4: When a character arrives while the queue holds 16 entries and no pop happens in that cycle, the character is dropped, the stored entries are unchanged and status bit 11 (overrun) is set. Bit 11 clears on the next pop.
- R5: Control bits 8:7 select the interrupt level: 0 selects 1 character, 1 selects 4, 2 selects 8 and 3 selects 12. Status bit 7 becomes 1 one cycle after the fill count is at or above the level.
- R6: Writing status bit 7 or bit 9 as 0 clears that bit, and writing it as 1 leaves it unchanged. A condition that still holds in the cycle of the write sets the bit again. Status bit 8 always reads 0.
- R7: Address 3 (bits 7:0, reset value 20) holds a limit N. When the queue is non-empty and N consecutive cycles pass with no arrival, status bit 9 sets on the following edge. A limit of 0 disables the timeout.
- R8: Writing control bit 15 as 1 makes it read 1 for one cycle. The block then empties the queue, clears every status flag, sets the level field to 0 and sets the limit to 20, and bit 15 returns to 0.
- R9: Writing control bits 1 and 0 both as 1 empties the queue and clears the overrun flag. Bit 1 written without bit 0 has no effect. Control bits 2:0 read 0.
- R10: `irq` is high exactly when status bit 7 or status bit 9 is 1.
- R11: A character that arrives in the same cycle as a pop is stored, including when the queue is full. The count is then unchanged and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push | input | 1 | Deserializer delivers a character this cycle |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break condition for this character |
| rx_frm | input | 1 | Framing error for this character |
| rx_par | input | 1 | Parity error for this character |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Receive interrupt |

## Verification
A character arrival and a data-register pop can land in the same clock edge, both at a partial fill and at a full queue. At a full queue the outcome decides between storing the character and raising an overrun. The bench provokes this by filling all 16 slots and then driving `rx_push` together with a read of address 0. It judges the result by the unchanged count, a clear overrun bit, and the new character appearing last when the queue is drained. A second collision, a write of 0 to clear a status bit in the same cycle that its condition still holds, is judged by the bit staying set.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH   = 16,
  parameter int TO_W    = 8,
  parameter int TO_INIT = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_push,
  input  logic [7:0]  rx_char,
  input  logic        rx_brk,
  input  logic        rx_frm,
  input  logic        rx_par,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [10:0]     mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   cnt, level;
  logic [TO_W-1:0] idle, tolim;
  logic [1:0]      thr;
  logic            ovr, rxs, tos, srst;

  wire        empty    = (cnt == '0);
  wire        full     = (cnt == CW'(DEPTH));
  wire        wr_st    = reg_wr && reg_addr == 2'd1;
  wire        wr_ctl   = reg_wr && reg_addr == 2'd2;
  wire        fifo_clr = wr_ctl && reg_wdata[0] && reg_wdata[1];
  wire        pop      = reg_rd && reg_addr == 2'd0 && !empty && !fifo_clr && !srst;
  wire        push_ok  = rx_push && (!full || pop) && !fifo_clr && !srst;
  wire [10:0] head     = empty ? 11'd0 : mem[rd_ptr];

  assign level = (thr == 2'd0) ? CW'(1) : CW'(thr) * CW'(DEPTH / 4);
  assign irq   = rxs | tos;

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= {rx_brk, rx_frm, rx_par, rx_char};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0; idle <= '0;
      tolim <= TO_W'(TO_INIT); thr <= '0;
      ovr <= 1'b0; rxs <= 1'b0; tos <= 1'b0; srst <= 1'b0;
    end else if (srst) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0; idle <= '0;
      tolim <= TO_W'(TO_INIT); thr <= '0;
      ovr <= 1'b0; rxs <= 1'b0; tos <= 1'b0; srst <= 1'b0;
    end else begin
      rxs <= ((wr_st && !reg_wdata[7]) ? 1'b0 : rxs) | (cnt >= level);
      tos <= ((wr_st && !reg_wdata[9]) ? 1'b0 : tos)
             | (!empty && tolim != '0 && idle == tolim);
      if (rx_push || empty) idle <= '0;
      else if (idle < tolim) idle <= idle + 1'b1;
      if (fifo_clr || pop) ovr <= 1'b0;
      else if (rx_push && full) ovr <= 1'b1;
      if (fifo_clr) begin
        rd_ptr <= '0; wr_ptr <= '0; cnt <= '0;
      end else begin
        if (pop) rd_ptr <= rd_ptr + 1'b1;
        if (push_ok) wr_ptr <= wr_ptr + 1'b1;
        cnt <= cnt + CW'(push_ok) - CW'(pop);
      end
      if (wr_ctl) begin
        srst <= reg_wdata[15];
        thr  <= reg_wdata[8:7];
      end
      if (reg_wr && reg_addr == 2'd3) tolim <= reg_wdata[TO_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'h00, head[7:0]};
      2'd1:    reg_rdata = {head[10], empty, head[9], head[8], ovr, 1'b0, tos,
                            1'b0, rxs, 2'b00, 5'(cnt)};
      2'd2:    reg_rdata = {srst, 6'b0, thr, 7'b0};
      default: reg_rdata = 16'(tolim);
    endcase
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && full && !pop && !fifo_clr && !srst) |=> (cnt == CW'(DEPTH) && ovr));
  p_srst_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!srst && cnt == '0 && !rxs && !tos));
  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop) |=> ($stable(cnt) && !ovr));
  p_timeout_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tos) |-> $past(!empty));
endmodule

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_push = 0, rx_brk = 0, rx_frm = 0, rx_par = 0;
  logic [7:0] rx_char = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 1;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  int q[$];
  bit m_ovr = 0, m_rxs = 0, m_tos = 0, m_srst = 0;
  int m_idle = 0, m_thr = 0, m_tol = 20;

  always #(PERIOD/2) clk = ~clk;

  uart_rx_fifo u_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  function automatic int level();
    return (m_thr == 0) ? 1 : m_thr * 4;
  endfunction

  function automatic logic [15:0] mread(int a);
    int s;
    case (a)
      0: return (q.size() > 0) ? 16'(q[0] & 255) : 16'h0;
      1: begin
        s = q.size() | (int'(m_rxs) << 7) | (int'(m_tos) << 9) | (int'(m_ovr) << 11);
        if (q.size() == 0) s |= 1 << 14;
        else s |= (((q[0] >> 10) & 1) << 15) | (((q[0] >> 9) & 1) << 13)
                  | (((q[0] >> 8) & 1) << 12);
        return 16'(s);
      end
      2: return 16'((int'(m_srst) << 15) | (m_thr << 7));
      default: return 16'(m_tol);
    endcase
  endfunction

  task automatic mstep(bit push, int ent, bit wr, bit rd, int a, logic [15:0] wd);
    int sz; bit clr, pop, full, pok, nrxs, ntos, novr; int nidle;
    if (m_srst) begin
      q.delete(); m_ovr = 0; m_rxs = 0; m_tos = 0; m_idle = 0;
      m_thr = 0; m_tol = 20; m_srst = 0;
      return;
    end
    sz = q.size();
    clr = wr && a == 2 && wd[0] && wd[1];
    pop = rd && a == 0 && sz > 0 && !clr;
    full = (sz == 16);
    pok = push && (!full || pop) && !clr;
    nrxs = ((wr && a == 1 && !wd[7]) ? 1'b0 : m_rxs) | (sz >= level());
    ntos = ((wr && a == 1 && !wd[9]) ? 1'b0 : m_tos) | (sz != 0 && m_tol != 0 && m_idle == m_tol);
    nidle = (push || sz == 0) ? 0 : ((m_idle < m_tol) ? m_idle + 1 : m_idle);
    novr = (clr || pop) ? 1'b0 : ((push && full) ? 1'b1 : m_ovr);
    if (clr) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (pok) q.push_back(ent);
    end
    if (wr && a == 2) begin m_srst = wd[15]; m_thr = int'(wd[8:7]); end
    if (wr && a == 3) m_tol = int'(wd[7:0]);
    m_rxs = nrxs; m_tos = ntos; m_idle = nidle; m_ovr = novr;
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit push, int ent, bit wr, bit rd, int a, logic [15:0] wd, string tag);
    logic [15:0] e;
    rx_push = push; rx_char = 8'(ent); rx_par = ent[8]; rx_frm = ent[9]; rx_brk = ent[10];
    reg_wr = wr; reg_rd = rd; reg_addr = 2'(a); reg_wdata = wd;
    #1;
    e = mread(a);
    chk(reg_rdata === e, tag, "rdata vs model", int'(reg_rdata), int'(e));
    chk(irq === (m_rxs | m_tos), tag, "irq vs model", int'(irq), int'(m_rxs | m_tos));
    mstep(push, ent, wr, rd, a, wd);
    @(negedge clk);
  endtask

  task automatic push(int ent, string tag);  cyc(1, ent, 0, 0, 1, 0, tag); endtask
  task automatic pop1(string tag);           cyc(0, 0, 0, 1, 0, 0, tag); endtask
  task automatic wreg(int a, logic [15:0] d, string tag); cyc(0, 0, 1, 0, a, d, tag); endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, tag);
  endtask
  task automatic expect_reg(int a, logic [15:0] exp, string tag);
    reg_addr = 2'(a); reg_rd = 0; reg_wr = 0; rx_push = 0;
    #1;
    chk(reg_rdata === exp, tag, "register", int'(reg_rdata), int'(exp));
    cyc(0, 0, 0, 0, a, 0, tag);
  endtask
  task automatic expect_irq(bit exp, string tag);
    #1;
    chk(irq === exp, tag, "irq", int'(irq), int'(exp));
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    expect_reg(1, 16'h4000, "R2");
    expect_reg(2, 16'h0000, "R8");
    expect_reg(3, 16'd20, "R7");
    // Head flags travel with characters
    push(32'h441, "R3");
    push(32'h242, "R3");
    push(32'h143, "R3");
    expect_reg(1, 16'h8083, "R3");
    expect_irq(1, "R10");
    expect_reg(0, 16'h0041, "R3");
    pop1("R3");
    expect_reg(1, 16'h2082, "R3");
    pop1("R3");
    expect_reg(1, 16'h1081, "R3");
    pop1("R3");
    expect_reg(1, 16'h4080, "R2");
    wreg(1, 16'h0000, "R6");
    expect_reg(1, 16'h4000, "R6");
    // Overrun on a full queue
    wreg(3, 16'h0000, "R7");
    for (int i = 0; i < 16; i++) push(32'h10 + i, "R1");
    expect_reg(1, 16'h0090, "R1");
    push(32'hEE, "R4");
    expect_reg(1, 16'h0890, "R4");
    expect_reg(0, 16'h0010, "R4");
    pop1("R4");
    expect_reg(1, 16'h008F, "R4");
    for (int i = 1; i < 16; i++) begin
      expect_reg(0, 16'(32'h10 + i), "R1");
      pop1("R1");
    end
    expect_reg(1, 16'h4080, "R4");
    // Arrival and pop in the same cycle at full
    for (int i = 0; i < 16; i++) push(32'h60 + i, "R11");
    cyc(1, 32'h77, 0, 1, 0, 0, "R11");
    expect_reg(1, 16'h0090, "R11");
    for (int i = 0; i < 15; i++) pop1("R11");
    expect_reg(0, 16'h0077, "R11");
    pop1("R11");
    // Partial fill collision
    push(32'h31, "R11");
    cyc(1, 32'h32, 0, 1, 0, 0, "R11");
    expect_reg(1, 16'h0081, "R11");
    expect_reg(0, 16'h0032, "R11");
    pop1("R11");
    wreg(1, 16'h0000, "R6");
    expect_reg(1, 16'h4000, "R6");
    // Threshold level 8
    wreg(2, 16'h0100, "R5");
    for (int i = 0; i < 7; i++) push(32'h20 + i, "R5");
    expect_reg(1, 16'h0007, "R5");
    expect_irq(0, "R10");
    push(32'h27, "R5");
    expect_reg(1, 16'h0008, "R5");
    expect_reg(1, 16'h0088, "R5");
    wreg(1, 16'h0280, "R6");
    expect_reg(1, 16'h0088, "R6");
    wreg(1, 16'h0000, "R6");
    expect_reg(1, 16'h0088, "R6");
    pop1("R6");
    wreg(1, 16'h0000, "R6");
    expect_reg(1, 16'h0007, "R6");
    // Guarded queue reset
    wreg(2, 16'h0102, "R9");
    expect_reg(1, 16'h0007, "R9");
    wreg(2, 16'h0103, "R9");
    expect_reg(1, 16'h4000, "R9");
    expect_reg(2, 16'h0100, "R9");
    // Timeout
    wreg(3, 16'd5, "R7");
    push(32'h55, "R7");
    idle(5, "R7");
    expect_irq(0, "R10");
    expect_reg(1, 16'h0001, "R7");
    expect_reg(1, 16'h0201, "R7");
    expect_irq(1, "R10");
    pop1("R7");
    wreg(1, 16'h0000, "R6");
    expect_reg(1, 16'h4000, "R7");
    // Soft reset
    push(32'h11, "R8");
    push(32'h12, "R8");
    wreg(2, 16'h8180, "R8");
    expect_reg(2, 16'h8180, "R8");
    expect_reg(2, 16'h0000, "R8");
    expect_reg(1, 16'h4000, "R8");
    expect_reg(3, 16'd20, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule